// File: doc/BRIEF.md
# Multi-Mode Serial Block Check Engine

This block computes a block check character one data bit per clock. A 16-bit check register collects the check value. A 16-bit data shift register holds the word being absorbed. Five check codes share one right-shifting datapath:

- three reflected CRCs: 12-bit, 16-bit and the CCITT form
- two longitudinal parity codes: an 8-bit and a 16-bit rotate-and-XOR

A 3-bit mode code and a double-length flag select the code and the number of bit cycles per word.

A host loads a data word, which re-arms the engine. It then either asks for a free run, which shifts one bit per clock until the pulse count is reached, or single-steps one bit at a time. The check register carries over from word to word, so a message is processed by loading its words in turn. A clear input zeroes the check register and sets done. The quotient bit of the latest cycle is always visible.

Top module: `bcc_shift_engine`

## Requirements
- R1: After synchronous reset, `check_out` is 0, `done` is 1 and `quo_bit` is 0.
- R2: Feedback constants by mode code: 0 uses 0x0F01, 1 uses 0xA001, 5 uses 0x8408. Codes 4, 6 and 7 are undefined.
- R3: With `cfg_wide` low, a word takes 6 bit cycles in mode 0 and 8 cycles in modes 1, 2, 3 and 5. With `cfg_wide` high these become 12 and 16. An undefined code finishes after exactly one cycle. `done` is 1 once the word is finished.
- R4: Each cycle forms the quotient q = check[0] XOR data[0]. It shifts the data register right by one and shows q on `quo_bit` from the next clock.
- R5: In CRC modes, the check register takes q into bit 0 and shifts right by one. When q is 1, it is then XORed with the mode's feedback constant.
- R6: In parity modes (code bit 1 set, with code bit 0 giving the width), the check register takes q into bit 0 and rotates right by one. With code bit 0 = 1 the rotate is over all 16 bits. With code bit 0 = 0 it is over bits [7:0] only, and bits [15:8] become 0.
- R7: In mode 0, bits [13:8] move down to [11:6] before the cycle, and bits [15:12] are dropped. After the cycle, bits [11:6] move up to [13:8], and bits 6, 7, 14 and 15 end as 0.
- R8: A `start_run` pulse performs one cycle on the same clock and one on every later clock until the pulse count is reached. `done` rises on the clock of the final cycle.
- R9: Each `step` pulse performs exactly one cycle.
- R10: While `done` is 1, `step` and `start_run` change nothing.
- R11: `clear` zeroes the check register and the pulse count and sets `done`. It keeps `quo_bit`. It wins over `load`, `step` and `start_run` in the same clock.
- R12: `load` copies `data_in` into the data register, clears `done` and zeroes the pulse count, and keeps the check register. It wins over `step` and `start_run` in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Check mode code |
| cfg_wide | input | 1 | Double-length word (two bytes) |
| data_in | input | 16 | Word to absorb |
| load | input | 1 | Load data word and re-arm |
| start_run | input | 1 | Run until the pulse count is reached |
| step | input | 1 | Perform one bit cycle |
| clear | input | 1 | Zero check and count, set done |
| check_out | output | 16 | Check register |
| quo_bit | output | 1 | Quotient of the latest cycle |
| done | output | 1 | Word finished, engine idle |

## Verification
Two pairs of controls can arrive in the same clock: `clear` together with `step` or `load`, and `load` together with `step`. The bench raises both inputs of each pair on one clock edge. For `clear` it expects a zero check register, `done` high and an unchanged quotient. For `load` it expects `done` low and the check register untouched. A single later step must then match exactly one modelled bit cycle, which shows that the step on the shared edge was dropped. Random words in all five defined modes, run both freely and stepped, are compared against a bench model of the bit cycle and the pulse counts.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int CHK_W = 16;
  localparam int CNT_W = 5;

  typedef enum logic [2:0] {
    MODE_CRC12 = 3'd0,
    MODE_CRC16 = 3'd1,
    MODE_PAR8  = 3'd2,
    MODE_PAR16 = 3'd3,
    MODE_RSV4  = 3'd4,
    MODE_CCITT = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } mode_e;

  typedef struct packed {
    logic [CHK_W-1:0] feedback;
    logic [CNT_W-1:0] pulses;
    logic             rotate;
    logic             rot_full;
    logic             pack6;
  } mode_cfg_t;
endpackage

// File: rtl/bcc_mode_decode.sv
module bcc_mode_decode
  import bcc_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       wide,
  output mode_cfg_t  cfg
);
  localparam logic [CNT_W-1:0] SHORT_CHAR = CNT_W'(6);
  localparam logic [CNT_W-1:0] BYTE_CHAR  = CNT_W'(8);

  logic [CNT_W-1:0] base;

  always_comb begin
    cfg.feedback = '0;
    base         = '0;
    unique case (mode_e'(mode))
      MODE_CRC12: begin cfg.feedback = 16'h0F01; base = SHORT_CHAR; end
      MODE_CRC16: begin cfg.feedback = 16'hA001; base = BYTE_CHAR;  end
      MODE_PAR8:  base = BYTE_CHAR;
      MODE_PAR16: base = BYTE_CHAR;
      MODE_CCITT: begin cfg.feedback = 16'h8408; base = BYTE_CHAR;  end
      default:    base = '0;
    endcase
    cfg.pulses   = wide ? (base << 1) : base;
    cfg.rotate   = mode[1];
    cfg.rot_full = mode[0];
    cfg.pack6    = (mode == MODE_CRC12);
  end
endmodule

// File: rtl/bcc_bit_step.sv
module bcc_bit_step
  import bcc_pkg::*;
(
  input  logic [CHK_W-1:0] chk_in,
  input  logic             dat_lsb,
  input  mode_cfg_t        cfg,
  output logic [CHK_W-1:0] chk_out,
  output logic             quo
);
  localparam int HALF = CHK_W / 2;

  logic [CHK_W-1:0] pre, mid, shf;

  always_comb begin
    pre = cfg.pack6 ? {4'b0000, chk_in[13:8], chk_in[5:0]} : chk_in;
    quo = pre[0] ^ dat_lsb;
    mid = {pre[CHK_W-1:1], quo};
    if (cfg.rotate) begin
      if (cfg.rot_full) shf = {mid[0], mid[CHK_W-1:1]};
      else              shf = {{HALF{1'b0}}, mid[0], mid[HALF-1:1]};
    end else begin
      shf = {1'b0, mid[CHK_W-1:1]} ^ (quo ? cfg.feedback : '0);
    end
    chk_out = cfg.pack6 ? {2'b00, shf[11:6], 2'b00, shf[5:0]} : shf;
  end
endmodule

// File: rtl/bcc_seq_ctrl.sv
module bcc_seq_ctrl
  import bcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic             start_run,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             fire,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign fire    = !done && !clear && !load && (step || start_run || running);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; done <= 1'b1; running <= 1'b0;
    end else if (clear) begin
      cnt <= '0; done <= 1'b1; running <= 1'b0;
    end else if (load) begin
      cnt <= '0; done <= 1'b0; running <= 1'b0;
    end else if (fire) begin
      cnt <= cnt_inc[CNT_W-1:0];
      if (cnt_inc >= {1'b0, limit}) begin
        done <= 1'b1; running <= 1'b0;
      end else begin
        running <= running || start_run;
      end
    end
  end

  // R3/R8/R9: done only rises from a performed cycle or a clear
  assert_done_source_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(fire) || $past(clear)));

  // R10: a free run never continues once the engine is done
  assert_idle_when_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !running);
endmodule

// File: rtl/bcc_shift_engine.sv
module bcc_shift_engine
  import bcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_wide,
  input  logic [CHK_W-1:0] data_in,
  input  logic             load,
  input  logic             start_run,
  input  logic             step,
  input  logic             clear,
  output logic [CHK_W-1:0] check_out,
  output logic             quo_bit,
  output logic             done
);
  mode_cfg_t        cfg;
  logic [CHK_W-1:0] dat_q, chk_nxt;
  logic             q_nxt, fire;

  bcc_mode_decode u_dec (.mode(cfg_mode), .wide(cfg_wide), .cfg(cfg));

  bcc_bit_step u_step (.chk_in(check_out), .dat_lsb(dat_q[0]), .cfg(cfg),
                       .chk_out(chk_nxt), .quo(q_nxt));

  bcc_seq_ctrl u_ctl (.clk(clk), .rst(rst), .clear(clear), .load(load),
                      .start_run(start_run), .step(step), .limit(cfg.pulses),
                      .fire(fire), .done(done));

  always_ff @(posedge clk) begin
    if (rst) begin
      check_out <= '0; dat_q <= '0; quo_bit <= 1'b0;
    end else if (clear) begin
      check_out <= '0;
    end else if (load) begin
      dat_q <= data_in;
    end else if (fire) begin
      check_out <= chk_nxt;
      dat_q     <= {1'b0, dat_q[CHK_W-1:1]};
      quo_bit   <= q_nxt;
    end
  end

  // R11: clear leaves a zero check register and done set
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
    clear |=> (done && check_out == '0));

  // R11: the quotient survives a clear
  assert_clear_keeps_quo_R11: assert property (@(posedge clk) disable iff (rst)
    clear |=> $stable(quo_bit));

  // R10: nothing moves while done without clear/load
  assert_hold_when_done_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !clear && !load) |=> ($stable(check_out) && $stable(quo_bit)));

  // R12: load re-arms and keeps the check register
  assert_load_rearms_R12: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> (!done && $stable(check_out)));

  // R6: 8-bit parity cycle leaves upper byte clear
  assert_par8_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && cfg_mode == MODE_PAR8) |=> (check_out[15:8] == 8'h00));
endmodule

// File: tb/bcc_shift_engine_bench.sv
module bcc_shift_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cfg_wide = 1'b0;
  logic [15:0] data_in = 16'h0;
  logic        load = 1'b0, start_run = 1'b0, step = 1'b0, clear = 1'b0;
  logic [15:0] check_out;
  logic        quo_bit, done;

  int n_chk = 0, n_bad = 0, wd = 0;
  logic [15:0] exp_chk = 16'h0;
  logic        exp_quo = 1'b0;

  always #2 clk = ~clk;

  bcc_shift_engine u_bcc_shift_engine (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
    .data_in(data_in), .load(load), .start_run(start_run), .step(step),
    .clear(clear), .check_out(check_out), .quo_bit(quo_bit), .done(done));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int pulses_of(input logic [2:0] m, input logic w);
    int b;
    case (m)
      3'd0: b = 6;
      3'd1, 3'd2, 3'd3, 3'd5: b = 8;
      default: b = 0;
    endcase
    return w ? 2 * b : b;
  endfunction

  function automatic logic [15:0] fb_of(input logic [2:0] m);
    case (m)
      3'd0: return 16'h0F01;
      3'd1: return 16'hA001;
      3'd5: return 16'h8408;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] model_bit(input logic [15:0] c, input logic d0,
                                            input logic [2:0] m, output logic q);
    logic [15:0] v;
    v = c;
    if (m == 3'd0) v = (v & 16'h003F) | ((v >> 2) & 16'h0FC0);
    q = v[0] ^ d0;
    v[0] = q;
    if (m[1]) begin
      if (m[0]) v = (v >> 1) | (v << 15);
      else      v = ((v & 16'h00FF) >> 1) | ((v & 16'h0001) << 7);
    end else begin
      v = v >> 1;
      if (q) v = v ^ fb_of(m);
    end
    if (m == 3'd0) v = (v & 16'h003F) | ((v & 16'h0FC0) << 2);
    return v;
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    if (m == 3'd0) return "R7";
    if (m[1] && m != 3'd6 && m != 3'd7) return "R6";
    if (m == 3'd1 || m == 3'd5) return "R5 R2";
    return "R3";
  endfunction

  task automatic pulse_load(input logic [15:0] d);
    data_in = d; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic run_word(input logic [2:0] m, input logic w, input logic [15:0] d,
                          input bit free_run);
    int n, cyc;
    logic [15:0] dd;
    cfg_mode = m; cfg_wide = w;
    pulse_load(d);
    chk("R12 done cleared by load", done, 1'b0);
    n = pulses_of(m, w);
    if (n == 0) n = 1;
    dd = d;
    for (int i = 0; i < n; i++) begin
      exp_chk = model_bit(exp_chk, dd[0], m, exp_quo);
      dd = dd >> 1;
    end
    if (free_run) begin
      start_run = 1'b1;
      @(negedge clk); start_run = 1'b0;
      cyc = 1;
      while (!done && cyc < 40) begin @(negedge clk); cyc++; end
      chk("R8 clocks until done", cyc, n);
    end else begin
      for (int i = 0; i < n; i++) begin
        if (i == n - 1 && n > 1) chk("R9 done low before last step", done, 1'b0);
        step = 1'b1; @(negedge clk); step = 1'b0;
      end
    end
    chk({tag_of(m), " check value"}, check_out, exp_chk);
    chk("R4 quotient", quo_bit, exp_quo);
    chk("R3 done after count", done, 1'b1);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] saved;
    logic [2:0]  m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset check", check_out, 16'h0);
    chk("R1 reset done", done, 1'b1);
    chk("R1 reset quo", quo_bit, 1'b0);

    // R10: step and start while done do nothing
    step = 1'b1; start_run = 1'b1;
    @(negedge clk); step = 1'b0; start_run = 1'b0;
    @(negedge clk);
    chk("R10 check held", check_out, 16'h0);
    chk("R10 done held", done, 1'b1);

    // directed: CRC-16 single byte, run
    run_word(3'd1, 1'b0, 16'h0031, 1'b1);
    // R3: undefined mode, one cycle
    run_word(3'd4, 1'b0, 16'h00FF, 1'b1);
    run_word(3'd7, 1'b1, 16'h1234, 1'b0);

    // R11: clear together with step mid-word
    cfg_mode = 3'd5; cfg_wide = 1'b1;
    pulse_load(16'hBEEF);
    step = 1'b1; @(negedge clk); step = 1'b0;
    exp_chk = model_bit(exp_chk, 1'b1, 3'd5, exp_quo);
    chk("R9 one step", check_out, exp_chk);
    clear = 1'b1; step = 1'b1; load = 1'b1;
    @(negedge clk); clear = 1'b0; step = 1'b0; load = 1'b0;
    chk("R11 clear zeroes", check_out, 16'h0);
    chk("R11 clear sets done", done, 1'b1);
    chk("R11 clear keeps quo", quo_bit, exp_quo);
    exp_chk = 16'h0;

    // R12: load together with step
    run_word(3'd1, 1'b0, 16'h00A5, 1'b0);
    saved = check_out;
    cfg_mode = 3'd1;
    data_in = 16'h0003; load = 1'b1; step = 1'b1;
    @(negedge clk); load = 1'b0; step = 1'b0;
    chk("R12 load beats step check", check_out, saved);
    chk("R12 load beats step done", done, 1'b0);
    step = 1'b1; @(negedge clk); step = 1'b0;
    exp_chk = model_bit(saved, 1'b1, 3'd1, exp_quo);
    chk("R12 first bit after load", check_out, exp_chk);
    chk("R4 quotient after load", quo_bit, exp_quo);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    exp_chk = 16'h0;

    // random words across defined modes
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 5)
        0: m = 3'd0;
        1: m = 3'd1;
        2: m = 3'd2;
        3: m = 3'd3;
        default: m = 3'd5;
      endcase
      if (i % 7 == 0) begin
        clear = 1'b1; @(negedge clk); clear = 1'b0;
        exp_chk = 16'h0;
      end
      run_word(m, 1'($urandom), 16'($urandom), bit'(i % 2));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule